// File: doc/BRIEF.md
# Tagged-Token Operand Matching Pipeline

This block is the front end of a tagged-token dataflow processor. Each incoming token carries a frame pointer, an instruction pointer, a port bit and a data value. The block uses the instruction pointer to fetch an instruction word from an external ROM. From that word it works out the address of an operand slot, then applies a matching rule to a frame store. The frame store holds one value and one presence flag per slot. When a two-input operator has both of its operands, the block passes the pair downstream, together with the token's pointers, so the token can be executed.

Code and operand storage are kept separate, so many activations can share one instruction while each uses its own frame region. Each two-input operator needs a single slot. That slot holds whichever operand arrives first until its partner turns up. The instruction word steers every stage directly, and there is no hazard detection. Tokens flow in order, one per cycle. A read-modify-write bypass makes a token see the slot update of the token one cycle ahead of it.

Top module: `mmp_token_match`

## Requirements
- R1: After reset every presence flag is clear and `out_valid` is low.
- R2: `rom_addr` follows `in_ip` in the same cycle, and `rom_data` is taken one cycle after the token is accepted. A token accepted at clock edge N produces its output, if it has one, in the cycle that follows edge N+2. When no token produced a result, `out_valid` is low.
- R3: Instruction word layout: bits [SLOT_W-1:0] are the offset, bit SLOT_W selects absolute addressing, bits [SLOT_W+3:SLOT_W+1] are the rule code, and higher bits are ignored. The slot is the offset alone when absolute addressing is selected. Otherwise it is (frame pointer + offset) modulo FRAME_DEPTH.
- R4: Normal rule (code 1) with the flag clear: the value is stored, the flag is set, and nothing is emitted.
- R5: Normal rule with the flag set: the pair is emitted and the flag is cleared. Port 0 puts the incoming value on `out_left` and the stored value on `out_right`; port 1 swaps them.
- R6: Unary rule (code 0) emits `out_left` = the value and `out_right` = 0, and leaves the frame store untouched.
- R7: Sticky rule (code 2) behaves like the normal rule, except that the flag and the stored value survive a match, so a stored constant pairs with every later token.
- R8: Exchange rule (code 3) with the flag set emits the pair ordered by port, keeps the flag set and replaces the stored value with the incoming one. With the flag clear it behaves like R4.
- R9: Imperative rule (code 4) writes the value, sets the flag and emits nothing, whatever the flag held before.
- R10: Rule codes 5 to 7 emit nothing and leave the slot unchanged.
- R11: A token that reaches the same slot one cycle after another token sees that token's update.
- R12: `out_fp` and `out_ip` carry the frame pointer and instruction pointer of the token that produced the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A token is presented this cycle |
| in_fp | input | SLOT_W | Token frame pointer |
| in_ip | input | IP_W | Token instruction pointer |
| in_port | input | 1 | Operand side: 0 = left, 1 = right |
| in_value | input | VAL_W | Token data value |
| rom_addr | output | IP_W | Instruction ROM address |
| rom_data | input | INSTR_W | Instruction word, one cycle after the address |
| out_valid | output | 1 | An operand pair is presented |
| out_fp | output | SLOT_W | Frame pointer of the emitting token |
| out_ip | output | IP_W | Instruction pointer of the emitting token |
| out_left | output | VAL_W | Left operand |
| out_right | output | VAL_W | Right operand, 0 for unary |

## Verification
The assertions check on every cycle that a normal first arrival stays silent, a normal match always emits, unary output has a zero right operand, reserved rule codes and idle cycles produce no output, and the bypass forwards the value being written to a same-slot read. Only the bench's scenarios can show that stored values come back in the right operand positions. The same holds for sticky constants surviving repeated matches, exchange replacing the held value, imperative overwrites being seen by later tokens, and address wrap-around landing on the intended slot. These effects depend on a history of several tokens, which the bench's behavioural model follows and compares on every clock.

// File: rtl/mmp_pkg.sv
package mmp_pkg;
   typedef logic [2:0] rule_t;
   localparam rule_t RULE_UNARY  = 3'd0;
   localparam rule_t RULE_NORMAL = 3'd1;
   localparam rule_t RULE_STICKY = 3'd2;
   localparam rule_t RULE_EXCH   = 3'd3;
   localparam rule_t RULE_IMPER  = 3'd4;
endpackage

// File: rtl/mmp_decode.sv
module mmp_decode
   import mmp_pkg::*;
#(
   parameter int INSTR_W = 12,
   parameter int SLOT_W  = 4
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic [SLOT_W-1:0]  fp,
   output rule_t              rule,
   output logic [SLOT_W-1:0]  ea
);
   localparam int ABS_BIT  = SLOT_W;
   localparam int RULE_LSB = SLOT_W + 1;

   if (INSTR_W < SLOT_W + 4) begin : g_bad_width
      $error("instruction word too narrow for offset, mode and rule");
   end

   logic [SLOT_W-1:0] offset;
   assign offset = instr[SLOT_W-1:0];
   assign rule   = instr[RULE_LSB +: 3];

   // slot count is a power of two, so truncation gives the modulo
   always_comb begin
      if (instr[ABS_BIT]) ea = offset;
      else                ea = fp + offset;
   end
endmodule

// File: rtl/mmp_frame_store.sv
module mmp_frame_store #(
   parameter int DEPTH  = 16,
   parameter int SLOT_W = 4,
   parameter int VAL_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [SLOT_W-1:0] rd_addr,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_addr,
   input  logic              wr_pres,
   input  logic [VAL_W-1:0]  wr_val,
   output logic              rd_pres_q,
   output logic [VAL_W-1:0]  rd_val_q
);
   if (DEPTH != (1 << SLOT_W)) begin : g_bad_depth
      $error("frame depth must equal 2**SLOT_W");
   end

   logic [DEPTH-1:0] pres;
   logic [VAL_W-1:0] vals [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)                                pres[i] <= 1'b0;
         else if (wr_en && wr_addr == SLOT_W'(i))   pres[i] <= wr_pres;
      end
      always_ff @(posedge clk) begin
         if (wr_en && wr_addr == SLOT_W'(i)) vals[i] <= wr_val;
      end
   end

   logic fwd;
   assign fwd = wr_en && (wr_addr == rd_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_pres_q <= 1'b0;
         rd_val_q  <= '0;
      end else if (rd_en) begin
         rd_pres_q <= fwd ? wr_pres : pres[rd_addr];
         rd_val_q  <= fwd ? wr_val  : vals[rd_addr];
      end
   end

   AST_BYPASS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en && rd_addr == wr_addr) |=>
      (rd_pres_q == $past(wr_pres) && rd_val_q == $past(wr_val))); // R11
endmodule

// File: rtl/mmp_match.sv
module mmp_match
   import mmp_pkg::*;
#(
   parameter int VAL_W = 16
) (
   input  logic             valid,
   input  rule_t            rule,
   input  logic             port,
   input  logic [VAL_W-1:0] value,
   input  logic             held,
   input  logic [VAL_W-1:0] held_val,
   output logic             emit,
   output logic [VAL_W-1:0] left,
   output logic [VAL_W-1:0] right,
   output logic             wr_en,
   output logic             wr_pres,
   output logic [VAL_W-1:0] wr_val
);
   always_comb begin
      emit    = 1'b0;
      wr_en   = 1'b0;
      wr_pres = 1'b0;
      wr_val  = value;
      left    = port ? held_val : value;
      right   = port ? value : held_val;
      if (valid) begin
         unique case (rule)
            RULE_UNARY: begin
               emit  = 1'b1;
               left  = value;
               right = '0;
            end
            RULE_NORMAL, RULE_STICKY, RULE_EXCH: begin
               if (!held) begin
                  wr_en   = 1'b1;
                  wr_pres = 1'b1;
               end else begin
                  emit = 1'b1;
                  if (rule == RULE_NORMAL) begin
                     wr_en   = 1'b1;
                     wr_pres = 1'b0;
                     wr_val  = held_val;
                  end else if (rule == RULE_EXCH) begin
                     wr_en   = 1'b1;
                     wr_pres = 1'b1;
                  end
               end
            end
            RULE_IMPER: begin
               wr_en   = 1'b1;
               wr_pres = 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mmp_token_match.sv
module mmp_token_match
   import mmp_pkg::*;
#(
   parameter int IP_W        = 8,
   parameter int VAL_W       = 16,
   parameter int FRAME_DEPTH = 16,
   parameter int INSTR_W     = 12
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   input  logic [$clog2(FRAME_DEPTH)-1:0] in_fp,
   input  logic [IP_W-1:0]                in_ip,
   input  logic                           in_port,
   input  logic [VAL_W-1:0]               in_value,
   output logic [IP_W-1:0]                rom_addr,
   input  logic [INSTR_W-1:0]             rom_data,
   output logic                           out_valid,
   output logic [$clog2(FRAME_DEPTH)-1:0] out_fp,
   output logic [IP_W-1:0]                out_ip,
   output logic [VAL_W-1:0]               out_left,
   output logic [VAL_W-1:0]               out_right
);
   localparam int SLOT_W = $clog2(FRAME_DEPTH);

   // stage 1: instruction word arrives from the ROM
   logic              s1_valid, s1_port;
   logic [SLOT_W-1:0] s1_fp;
   logic [IP_W-1:0]   s1_ip;
   logic [VAL_W-1:0]  s1_val;

   assign rom_addr = in_ip;

   always_ff @(posedge clk) begin
      if (!rst_n) s1_valid <= 1'b0;
      else        s1_valid <= in_valid;
      s1_fp   <= in_fp;
      s1_ip   <= in_ip;
      s1_port <= in_port;
      s1_val  <= in_value;
   end

   rule_t             d_rule;
   logic [SLOT_W-1:0] d_ea;

   mmp_decode #(.INSTR_W(INSTR_W), .SLOT_W(SLOT_W)) u_decode (
      .instr (rom_data),
      .fp    (s1_fp),
      .rule  (d_rule),
      .ea    (d_ea)
   );

   // stage 2: slot contents available, rule applied
   logic              s2_valid, s2_port;
   rule_t             s2_rule;
   logic [SLOT_W-1:0] s2_ea, s2_fp;
   logic [IP_W-1:0]   s2_ip;
   logic [VAL_W-1:0]  s2_val;

   always_ff @(posedge clk) begin
      if (!rst_n) s2_valid <= 1'b0;
      else        s2_valid <= s1_valid;
      s2_rule <= d_rule;
      s2_ea   <= d_ea;
      s2_fp   <= s1_fp;
      s2_ip   <= s1_ip;
      s2_port <= s1_port;
      s2_val  <= s1_val;
   end

   logic             fs_pres, m_emit, m_wr, m_wr_pres;
   logic [VAL_W-1:0] fs_val, m_left, m_right, m_wr_val;

   mmp_frame_store #(.DEPTH(FRAME_DEPTH), .SLOT_W(SLOT_W), .VAL_W(VAL_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (s1_valid),
      .rd_addr   (d_ea),
      .wr_en     (m_wr),
      .wr_addr   (s2_ea),
      .wr_pres   (m_wr_pres),
      .wr_val    (m_wr_val),
      .rd_pres_q (fs_pres),
      .rd_val_q  (fs_val)
   );

   mmp_match #(.VAL_W(VAL_W)) u_match (
      .valid    (s2_valid),
      .rule     (s2_rule),
      .port     (s2_port),
      .value    (s2_val),
      .held     (fs_pres),
      .held_val (fs_val),
      .emit     (m_emit),
      .left     (m_left),
      .right    (m_right),
      .wr_en    (m_wr),
      .wr_pres  (m_wr_pres),
      .wr_val   (m_wr_val)
   );

   // stage 3: registered operand pair
   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= m_emit;
      out_fp    <= s2_fp;
      out_ip    <= s2_ip;
      out_left  <= m_left;
      out_right <= m_right;
   end

   AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && s2_rule == RULE_NORMAL && !fs_pres) |=> !out_valid); // R4
   AST_PAIR_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && s2_rule == RULE_NORMAL && fs_pres) |=> out_valid); // R5
   AST_UNARY_RIGHT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && s2_rule == RULE_UNARY) |=> (out_valid && out_right == '0)); // R6
   AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && s2_rule > RULE_IMPER) |=> !out_valid); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !s2_valid |=> !out_valid); // R2
endmodule

// File: tb/tb_mmp_token_match.sv
module tb_mmp_token_match;
   localparam int CLK_PERIOD = 10;
   localparam int IP_W = 8, VAL_W = 16, DEPTH = 16, INSTR_W = 12, SW = 4;

   logic clk = 0, rst_n = 0;
   logic in_valid = 0, in_port = 0;
   logic [SW-1:0] in_fp = 0;
   logic [IP_W-1:0] in_ip = 0;
   logic [VAL_W-1:0] in_value = 0;
   logic [IP_W-1:0] rom_addr;
   logic [INSTR_W-1:0] rom_data = 0;
   logic out_valid;
   logic [SW-1:0] out_fp;
   logic [IP_W-1:0] out_ip;
   logic [VAL_W-1:0] out_left, out_right;

   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mmp_token_match #(.IP_W(IP_W), .VAL_W(VAL_W), .FRAME_DEPTH(DEPTH), .INSTR_W(INSTR_W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fp(in_fp), .in_ip(in_ip),
      .in_port(in_port), .in_value(in_value), .rom_addr(rom_addr), .rom_data(rom_data),
      .out_valid(out_valid), .out_fp(out_fp), .out_ip(out_ip),
      .out_left(out_left), .out_right(out_right));

   // instruction layout (R3): [3:0] offset, [4] absolute, [7:5] rule
   function automatic logic [INSTR_W-1:0] prog(input logic [IP_W-1:0] ip);
      case (ip)
         8'd0: prog = {4'd0, 3'd1, 1'b0, 4'd1};   // normal, relative +1
         8'd1: prog = {4'd0, 3'd0, 1'b0, 4'd0};   // unary
         8'd2: prog = {4'd0, 3'd2, 1'b0, 4'd2};   // sticky, relative +2
         8'd3: prog = {4'd0, 3'd3, 1'b1, 4'd9};   // exchange, absolute 9
         8'd4: prog = {4'd0, 3'd4, 1'b1, 4'd9};   // imperative, absolute 9
         8'd5: prog = {4'd0, 3'd6, 1'b0, 4'd1};   // reserved code, relative +1
         8'd6: prog = {4'd0, 3'd1, 1'b1, 4'd15};  // normal, absolute 15
         8'd7: prog = {4'd0, 3'd1, 1'b0, 4'd3};   // normal, relative +3 (wraps)
         default: prog = {4'hF, 3'd0, 1'b0, 4'd0};
      endcase
   endfunction

   always @(posedge clk) rom_data <= prog(rom_addr);

   // behavioural reference model
   bit m_pres [DEPTH];
   logic [VAL_W-1:0] m_val [DEPTH];
   int prev_slot = -1;
   logic e1v = 0, e2v = 0, e3v = 0;
   logic [VAL_W-1:0] e1l, e2l, e3l, e1r, e2r, e3r;
   logic [SW-1:0] e1f, e2f, e3f;
   logic [IP_W-1:0] e1i, e2i, e3i;
   string t1 = "R2", t2 = "R2", t3 = "R2";

   always @(posedge clk) begin
      logic emit;
      logic [VAL_W-1:0] l, r;
      string tag;
      int slot, rule;
      logic [INSTR_W-1:0] w;
      emit = 0; l = 0; r = 0; tag = "R2";
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) m_pres[k] = 0;
         prev_slot = -1;
      end else if (in_valid) begin
         w = prog(in_ip);
         rule = int'(w[7:5]);
         slot = w[4] ? int'(w[3:0]) : (int'(in_fp) + int'(w[3:0])) % DEPTH;
         l = in_port ? m_val[slot] : in_value;
         r = in_port ? in_value : m_val[slot];
         case (rule)
            0: begin emit = 1; l = in_value; r = 0; tag = "R6"; end
            1, 2, 3: begin
               if (!m_pres[slot]) begin
                  m_pres[slot] = 1; m_val[slot] = in_value; tag = "R4";
               end else begin
                  emit = 1;
                  if (rule == 1) begin m_pres[slot] = 0; tag = "R5"; end
                  else if (rule == 3) begin m_val[slot] = in_value; tag = "R8"; end
                  else tag = "R7";
               end
            end
            4: begin m_pres[slot] = 1; m_val[slot] = in_value; tag = "R9"; end
            default: tag = "R10";
         endcase
         if (in_ip == 8'd6 || in_ip == 8'd7) tag = "R3";
         if (rule != 0 && slot == prev_slot) tag = "R11";
         prev_slot = (rule == 0) ? -1 : slot;
      end else prev_slot = -1;
      e1v <= rst_n && in_valid && emit; e1l <= l; e1r <= r; e1f <= in_fp; e1i <= in_ip; t1 <= tag;
      e2v <= e1v && rst_n; e2l <= e1l; e2r <= e1r; e2f <= e1f; e2i <= e1i; t2 <= t1;
      e3v <= e2v && rst_n; e3l <= e2l; e3r <= e2r; e3f <= e2f; e3i <= e2i; t3 <= t2;
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (out_valid !== e3v) begin
            errors++;
            $display("FAIL %s out_valid actual %0b expected %0b", t3, out_valid, e3v);
         end else if (e3v) begin
            if (out_left !== e3l || out_right !== e3r) begin
               errors++;
               $display("FAIL %s pair actual %h/%h expected %h/%h", t3, out_left, out_right, e3l, e3r);
            end
            if (out_fp !== e3f || out_ip !== e3i) begin
               errors++;
               $display("FAIL R12 pointers actual %h/%h expected %h/%h", out_fp, out_ip, e3f, e3i);
            end
         end
      end
   end

   task automatic send(input int fp, input int ip, input bit port, input int v);
      @(negedge clk);
      in_valid = 1; in_fp = SW'(fp); in_ip = IP_W'(ip); in_port = port; in_value = VAL_W'(v);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;  // R1 reset state
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 out_valid actual %0b expected 0", out_valid);
      end
      rst_n = 1;
      idle(2);
      // R4/R5 normal pair, right then left
      send(2, 0, 1, 'h1111); idle(2); send(2, 0, 0, 'h2222); idle(4);
      // R11 back-to-back to the same slot
      send(10, 0, 0, 'h0A0A); send(10, 0, 1, 'h0B0B); idle(4);
      // R6 unary
      send(5, 1, 1, 'h7777); idle(4);
      // R7 sticky constant reused three times
      send(3, 2, 1, 'h00C0); send(3, 2, 0, 'h0001); send(3, 2, 0, 'h0002); send(3, 2, 0, 'h0003); idle(4);
      // R8 exchange, R9 imperative overwrite then exchange sees it
      send(0, 3, 0, 'h0E01); idle(1); send(0, 3, 1, 'h0E02); idle(1); send(0, 3, 0, 'h0E03);
      send(0, 4, 0, 'h0F0F); idle(1); send(0, 3, 1, 'h0E04); idle(4);
      // R10 reserved code between a normal pair on slot 1
      send(0, 0, 0, 'h1234); idle(1); send(0, 5, 1, 'hDEAD); idle(1); send(0, 0, 1, 'h5678); idle(4);
      // R3 wrap (14+3 -> slot 1) and absolute slot 15
      send(14, 7, 1, 'h3333); idle(1); send(14, 7, 0, 'h4444);
      send(9, 6, 0, 'h6661); send(2, 6, 1, 'h6662); idle(4);
      // mixed traffic
      for (int k = 0; k < 400; k++) begin
         if ($urandom_range(0, 3) == 0) idle(1);
         else send($urandom_range(0, 15), $urandom_range(0, 8), 1'($urandom_range(0, 1)),
                   $urandom_range(0, 65535));
      end
      idle(6);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule